// File: doc/BRIEF.md
# Secondary I2C Address Match Flag

This block monitors an I2C bus while the device acts as a slave receiver. It watches the already-synchronized SCL and SDA lines and picks up the first byte that follows each START condition. It compares the seven address bits of that byte with a programmable secondary slave address. On a match, the block emits a one-cycle match pulse and sets a sticky recognition flag.

The flag stays set until one of three things happens. Software can clear it by reading it as 1 and then writing 0 to it. Any START condition on the bus also clears it, and the flag is held at 0 for as long as the interface is in master mode. A separate format-select input turns secondary-address recognition off when it is high. The read data of the register bus is the flag output itself.

Top module: `sec_addr_flag`

## Requirements
- R1: The block samples SDA on each rising SCL edge, most significant bit first. When the first byte after a START has its bits 7..1 equal to `sec_addr_i`, and `master_i`=0, `transmit_i`=0 and `sec_fmt_i`=0, then `match_o` pulses and `flag_o` becomes 1. Bit 0 of the byte (the read/write bit) plays no part in the comparison.
- R2: While `sec_fmt_i`=1, a matching address byte neither pulses `match_o` nor sets `flag_o`.
- R3: A write with `wr_i`=1 and `wdata_i`=0 clears `flag_o` only if an earlier cycle had `rd_i`=1 while `flag_o` was 1, with no write in between. A write of 0 without such a read leaves the flag at 1. A write of 1 never changes the flag and cancels a pending read.
- R4: A START condition clears `flag_o` in the cycle after it is detected.
- R5: While `master_i`=1, `flag_o` is 0 from the next cycle on, and a matching byte does not set it.
- R6: Only the first byte after a START is compared. Later bytes that match never set the flag.
- R7: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A STOP during a partly received first byte abandons that byte. A repeated START during a byte restarts capture from bit 7.
- R8: In slave transmit mode (`transmit_i`=1), a matching byte does not set the flag.
- R9: After reset, `flag_o` and `match_o` are 0.
- R10: `match_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| master_i | input | 1 | 1 = interface is in master mode |
| transmit_i | input | 1 | 1 = interface is transmitting |
| sec_addr_i | input | ADDR_W | Secondary slave address |
| sec_fmt_i | input | 1 | Format select; 1 disables secondary recognition |
| rd_i | input | 1 | Register read strobe for the flag |
| wr_i | input | 1 | Register write strobe for the flag |
| wdata_i | input | 1 | Value written to the flag |
| flag_o | output | 1 | Sticky recognition flag; also the read data |
| match_o | output | 1 | One-cycle pulse on an address match |

## Verification
The assertions check the following on every cycle:
- The flag only rises after a match pulse, and only in slave receive with recognition enabled.
- START and master mode force the flag low on the next cycle.
- Any fall of the flag not explained by START or master mode follows a write of 0.
- The match pulse is one cycle wide.

Some behaviours depend on how bus events and register accesses are ordered over time. These are shown only by the bench scenarios:
- Which byte is compared.
- That STOP abandons a partial frame and a repeated START restarts capture.
- The read-then-write-zero rule, and that a write of 0 without a prior read is ignored.
- That the read/write bit does not affect the comparison.

// File: rtl/sec_addr_pkg.sv
package sec_addr_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_ev_t;
endpackage

// File: rtl/sec_bus_events.sv
module sec_bus_events
  import sec_addr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.start    = scl_q & scl_i & sda_q & ~sda_i;
    ev_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
    ev_o.scl_rise = ~scl_q & scl_i;
  end
endmodule

// File: rtl/sec_frame_capture.sv
module sec_frame_capture
  import sec_addr_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  bus_ev_t            ev_i,
  input  logic               sda_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               in_frame_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_i.start) begin
        cnt_q      <= '0;
        in_frame_q <= 1'b1;
      end else if (ev_i.stop) begin
        in_frame_q <= 1'b0;
      end else if (ev_i.scl_rise && in_frame_q) begin
        shift_q <= {shift_q[FRAME_W-2:0], sda_i};
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          in_frame_q <= 1'b0;  // only the first frame is compared
          done_q     <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign frame_o = shift_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sec_flag_reg.sv
module sec_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic start_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);
  logic flag_q, armed_q, sw_clr;

  assign sw_clr = wr_i & ~wdata_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_i || !flag_q) armed_q <= 1'b0;
      else if (rd_i)       armed_q <= 1'b1;

      if (master_i)     flag_q <= 1'b0;
      else if (start_i) flag_q <= 1'b0;
      else if (set_i)   flag_q <= 1'b1;  // set beats software clear
      else if (sw_clr)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sec_addr_flag.sv
module sec_addr_flag
  import sec_addr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              master_i,
  input  logic              transmit_i,
  input  logic [ADDR_W-1:0] sec_addr_i,
  input  logic              sec_fmt_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wdata_i,
  output logic              flag_o,
  output logic              match_o
);
  localparam int FRAME_W = ADDR_W + 1;

  bus_ev_t            bus_ev;
  logic [FRAME_W-1:0] frame;
  logic               frame_done;
  logic               start_det;
  logic               addr_hit;
  logic               slave_rx;

  sec_bus_events u_events (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (bus_ev)
  );

  sec_frame_capture #(.FRAME_W(FRAME_W)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (bus_ev),
    .sda_i  (sda_i),
    .frame_o(frame),
    .done_o (frame_done)
  );

  assign start_det = bus_ev.start;
  assign addr_hit  = (frame[FRAME_W-1:1] == sec_addr_i);
  assign slave_rx  = ~master_i & ~transmit_i;
  assign match_o   = frame_done & addr_hit & slave_rx & ~sec_fmt_i;

  sec_flag_reg u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_i),
    .start_i (start_det),
    .set_i   (match_o),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .flag_o  (flag_o)
  );
endmodule

// File: rtl/sec_addr_flag_chk.sv
module sec_addr_flag_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic transmit_i,
  input logic sec_fmt_i,
  input logic wr_i,
  input logic wdata_i,
  input logic start_det,
  input logic flag_o,
  input logic match_o
);
  AST_RISE_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(match_o)); // R1
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && !start_det |=> flag_o); // R1
  AST_RISE_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(!sec_fmt_i && !transmit_i)); // R2
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !flag_o); // R4
  AST_MASTER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> !flag_o); // R5
  AST_FALL_NEEDS_WRITE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) && !$past(master_i) && !$past(start_det) |-> $past(wr_i && !wdata_i)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o); // R10
endmodule

bind sec_addr_flag sec_addr_flag_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .transmit_i(transmit_i),
  .sec_fmt_i (sec_fmt_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .start_det (start_det),
  .flag_o    (flag_o),
  .match_o   (match_o)
);

// File: tb/sec_addr_flag_bench.sv
`timescale 1ns/1ps
module sec_addr_flag_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic master = 1'b0, transmit = 1'b0, fmt = 1'b0;
  logic [6:0] addr = 7'h5A;
  logic rd = 1'b0, wr = 1'b0, wdata = 1'b0;
  logic flag, match;
  int checks = 0, failures = 0, pulses = 0, wide = 0;
  logic match_prev = 1'b0;

  always #10 clk = ~clk;

  sec_addr_flag u_sec_addr_flag (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_i(master), .transmit_i(transmit), .sec_addr_i(addr),
    .sec_fmt_i(fmt), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .flag_o(flag), .match_o(match)
  );

  always @(posedge clk) begin
    if (rst_n && match) pulses++;
    if (rst_n && match && match_prev) wide++;
    match_prev <= rst_n && match;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_int(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; tick(2);
    sda = 1'b0; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(2);
    scl = 1'b1; tick(2);
    sda = 1'b1; tick(2);
  endtask

  task automatic bus_bit(logic b);
    sda = b; tick(2);
    scl = 1'b1; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  task automatic reg_read();
    rd = 1'b1; tick(); rd = 1'b0; tick();
  endtask

  task automatic reg_write(logic v);
    wr = 1'b1; wdata = v; tick(); wr = 1'b0; wdata = 1'b0; tick();
  endtask

  task automatic set_flag();
    bus_start(); send_byte({addr, 1'b0}); tick(2);
  endtask

  task automatic t_reset();
    check(flag, 1'b0, "R9", "flag after reset");
    check(match, 1'b0, "R9", "match after reset");
  endtask

  task automatic t_match();
    int p0 = pulses;
    set_flag();
    check(flag, 1'b1, "R1", "flag on address match rw=0");
    check_int(pulses - p0, 1, "R1", "one match pulse");
    bus_start(); send_byte({addr, 1'b1}); tick(2);
    check(flag, 1'b1, "R1", "flag on address match rw=1");
    addr = 7'h01;
    bus_start(); send_byte(8'h03); tick(2);
    check(flag, 1'b1, "R1", "flag on address 01");
    addr = 7'h5A;
  endtask

  task automatic t_mismatch();
    int p0 = pulses;
    bus_start(); send_byte({7'h5B, 1'b0}); tick(2);
    check(flag, 1'b0, "R1", "no flag on mismatch");
    check_int(pulses - p0, 0, "R1", "no pulse on mismatch");
  endtask

  task automatic t_start_clear();
    set_flag();
    check(flag, 1'b1, "R4", "flag set before start");
    bus_start();
    check(flag, 1'b0, "R4", "flag cleared by start");
    bus_stop();
  endtask

  task automatic t_fmt();
    int p0 = pulses;
    fmt = 1'b1;
    bus_start(); send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b0, "R2", "no flag when format select high");
    check_int(pulses - p0, 0, "R2", "no pulse when format select high");
    fmt = 1'b0;
  endtask

  task automatic t_transmit();
    transmit = 1'b1;
    bus_start(); send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b0, "R8", "no flag in slave transmit");
    transmit = 1'b0;
  endtask

  task automatic t_master();
    int p0 = pulses;
    master = 1'b1;
    bus_start(); send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b0, "R5", "no flag in master mode");
    check_int(pulses - p0, 0, "R5", "no pulse in master mode");
    master = 1'b0;
    set_flag();
    check(flag, 1'b1, "R5", "flag set in slave rx");
    master = 1'b1; tick();
    check(flag, 1'b0, "R5", "master mode clears flag");
    master = 1'b0; tick(2);
    check(flag, 1'b0, "R5", "flag stays clear after master");
  endtask

  task automatic t_swclear();
    set_flag();
    reg_write(1'b0);
    check(flag, 1'b1, "R3", "write 0 without read ignored");
    reg_read(); reg_write(1'b1);
    check(flag, 1'b1, "R3", "write 1 ignored");
    reg_write(1'b0);
    check(flag, 1'b1, "R3", "write 1 cancelled the read");
    reg_read(); reg_write(1'b0);
    check(flag, 1'b0, "R3", "read then write 0 clears");
  endtask

  task automatic t_first_only();
    int p0 = pulses;
    bus_start(); send_byte(8'h00); bus_bit(1'b0);
    send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b0, "R6", "second byte never sets flag");
    check_int(pulses - p0, 0, "R6", "no pulse on second byte");
    bus_stop();
  endtask

  task automatic t_stop_restart();
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1);
    bus_stop();
    scl = 1'b0; tick(2);
    send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b0, "R7", "stop abandons partial frame");
    bus_start();
    bus_bit(1'b0); bus_bit(1'b0); bus_bit(1'b0);
    bus_start();
    send_byte({addr, 1'b0}); tick(2);
    check(flag, 1'b1, "R7", "repeated start restarts capture");
    bus_stop();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_match();
    t_mismatch();
    t_start_clear();
    t_fmt();
    t_transmit();
    t_master();
    t_swclear();
    t_first_only();
    t_stop_restart();
    check_int(wide, 0, "R10", "match pulse width one cycle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule